// File: doc/BRIEF.md
# Bidirectional even-value sequence generator

This block is a synchronous three-bit state machine that visits only the even codes 0, 2, 4 and 6. A direction line picks the order. Forward order runs 2, 4, 6, 0 and then repeats. Reverse order runs 0, 6, 4, 2 and then repeats. The state is held in three JK-style storage bits. Each bit takes its J and K inputs from excitation logic, which compares the present code with the wanted next code.

The four odd codes are never part of the sequence. The machine can reach one of them only through a disturbance, or through the synchronous seed path that the block provides for that purpose. From any odd code, the next count step returns the machine to 0, in either direction. The cycle after such a return, a one-cycle recovery flag is raised.

The block is used as a free-running or gated phase sequencer. It has a synchronous reset and a count enable. A synchronous seed load writes any code into the state. All control pins are plain levels sampled on the rising clock edge, and no pin carries a handshake.

Top module: `evenseq_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the edge sets `seq_o` to 0, `dir_o` to 0 and `recover_o` to 0, whatever `cnt_en`, `seed_load` and `dir_sel` are.
- R2: With `dir_sel` = 0, each count step (`cnt_en` = 1, `seed_load` = 0) moves `seq_o` 0→2→4→6→0.
- R3: With `dir_sel` = 1, each count step moves `seq_o` 0→6→4→2→0.
- R4: From any odd code (1, 3, 5 or 7), a count step sets `seq_o` to 0, for both values of `dir_sel`.
- R5: `dir_sel` is sampled on the same edge as the step it steers. A change of `dir_sel` therefore applies to the very next step, with no extra cycle of delay.
- R6: When `cnt_en` = 0 and `seed_load` = 0, every state bit receives J=0 and K=0. `seq_o` and `dir_o` then hold, for any code, including an odd one, and for any value of `dir_sel`.
- R7: `recover_o` is 1 for exactly the one cycle after a count step that took `seq_o` from an odd code to 0. It is 0 after legal steps, after loads, after hold cycles and after reset.
- R8: When `seed_load` = 1 and `rst` = 0, the edge writes `seed_code` into `seq_o`, any of the eight codes, whatever `cnt_en` is. A load does not change `dir_o`.
- R9: `dir_o` shows the `dir_sel` value used by the most recent count step: 0 means forward and 1 means reverse.
- R10: Each state bit's J is 1 only when that bit must go from 0 to 1, and its K is 1 only when that bit must go from 1 to 0. For all 16 pairs of present code and direction, the result equals the next-state rule of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable: a step happens on each edge where it is high and no load is taking place |
| dir_sel | input | 1 | Step order: 0 forward, 1 reverse |
| seed_load | input | 1 | Synchronous load strobe for `seed_code` |
| seed_code | input | 3 | Code written into the state on a load |
| seq_o | output | 3 | Present state code |
| dir_o | output | 1 | Direction used by the last count step |
| recover_o | output | 1 | One-cycle pulse after a return from an odd code |

## Verification
The odd codes are the hardest condition to bring about. Reset and every legal step keep the machine on even values, so the count path alone never reaches 1, 3, 5 or 7. The stimulus therefore loads each of the eight codes through the synchronous seed path, follows it with one count step in each direction, and so covers all 16 state and direction pairs. Directed cases then leave an odd code parked with the enable low, and reset from an odd code, to show that neither action raises the recovery flag.

// File: rtl/evenseq_pkg.sv
package evenseq_pkg;
  localparam int unsigned SEQ_W  = 3;
  localparam int unsigned STRIDE = 2;

  typedef logic [SEQ_W-1:0] code_t;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  typedef struct packed {
    logic [SEQ_W-1:0] j;
    logic [SEQ_W-1:0] k;
  } jk_t;

  // a code belongs to the sequence only when its lowest bit is clear
  function automatic logic code_is_odd(code_t c);
    return c[0];
  endfunction
endpackage

// File: rtl/evenseq_next.sv
module evenseq_next
  import evenseq_pkg::*;
(
  input  code_t cur,
  input  logic  dir,
  output code_t nxt,
  output logic  bad
);
  code_t up_val;
  code_t dn_val;

  // modular arithmetic gives both wraps: 6+2 -> 0 and 0-2 -> 6
  assign up_val = code_t'(cur + code_t'(STRIDE));
  assign dn_val = code_t'(cur - code_t'(STRIDE));
  assign bad    = code_is_odd(cur);

  always_comb begin
    if (bad) begin
      nxt = '0;
    end else begin
      unique case (dir_e'(dir))
        DIR_FWD: nxt = up_val;
        DIR_REV: nxt = dn_val;
        default: nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/evenseq_excite.sv
module evenseq_excite
  import evenseq_pkg::*;
#(
  parameter int unsigned W = SEQ_W
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] target,
  input  logic         upd,
  output logic [W-1:0] j,
  output logic [W-1:0] k
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    // set only on a 0->1 move, clear only on a 1->0 move, else hold
    assign j[b] = upd & ~q[b] &  target[b];
    assign k[b] = upd &  q[b] & ~target[b];
  end
endmodule

// File: rtl/evenseq_jkreg.sv
module evenseq_jkreg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst) begin
        q[b] <= 1'b0;
      end else begin
        unique case ({j[b], k[b]})
          2'b00:   q[b] <= q[b];
          2'b10:   q[b] <= 1'b1;
          2'b01:   q[b] <= 1'b0;
          default: q[b] <= ~q[b];
        endcase
      end
    end

    // R10
    jk_set_chk: assert property (@(posedge clk) disable iff (rst)
      (j[b] && !k[b]) |=> q[b]);
    // R10
    jk_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (k[b] && !j[b]) |=> !q[b]);
    // R6
    jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!j[b] && !k[b]) |=> $stable(q[b]));
  end
endmodule

// File: rtl/evenseq_gen.sv
module evenseq_gen
  import evenseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             dir_sel,
  input  logic             seed_load,
  input  logic [SEQ_W-1:0] seed_code,
  output logic [SEQ_W-1:0] seq_o,
  output logic             dir_o,
  output logic             recover_o
);
  code_t cur;
  code_t nxt;
  code_t target;
  logic  bad;
  logic  step;
  logic  upd;
  jk_t   jk;
  logic  dir_q;
  logic  rec_q;

  assign step   = cnt_en & ~seed_load;
  assign upd    = cnt_en | seed_load;
  assign target = seed_load ? seed_code : nxt;

  evenseq_next u_next (
    .cur (cur),
    .dir (dir_sel),
    .nxt (nxt),
    .bad (bad)
  );

  evenseq_excite #(.W(SEQ_W)) u_exc (
    .q      (cur),
    .target (target),
    .upd    (upd),
    .j      (jk.j),
    .k      (jk.k)
  );

  evenseq_jkreg #(.W(SEQ_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .j   (jk.j),
    .k   (jk.k),
    .q   (cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      rec_q <= 1'b0;
    end else begin
      if (step) dir_q <= dir_sel;
      rec_q <= step & bad;
    end
  end

  assign seq_o     = cur;
  assign dir_o     = dir_q;
  assign recover_o = rec_q;

  // R2
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !dir_sel && !seq_o[0]) |=> (seq_o == code_t'($past(seq_o) + 3'd2)));
  // R3
  rev_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && dir_sel && !seq_o[0]) |=> (seq_o == code_t'($past(seq_o) - 3'd2)));
  // R4
  odd_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step && seq_o[0]) |=> (seq_o == 3'd0));
  // R7
  rec_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(recover_o) |-> ($past(seq_o[0]) && seq_o == 3'd0));
  // R7
  rec_single_chk: assert property (@(posedge clk) disable iff (rst)
    recover_o |=> !recover_o);
  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (seq_o == $past(seed_code) && $stable(dir_o)));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !seed_load) |=> ($stable(seq_o) && $stable(dir_o)));
endmodule

// File: tb/sim_evenseq_gen.sv
module sim_evenseq_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       cnt_en;
  logic       dir_sel;
  logic       seed_load;
  logic [2:0] seed_code;
  logic [2:0] seq_o;
  logic       dir_o;
  logic       recover_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  evenseq_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .dir_sel   (dir_sel),
    .seed_load (seed_load),
    .seed_code (seed_code),
    .seq_o     (seq_o),
    .dir_o     (dir_o),
    .recover_o (recover_o)
  );

  // {seed[2:0], dir, expected next[2:0], expected flag}
  localparam logic [7:0] VEC [16] = '{
    {3'd0, 1'b0, 3'd2, 1'b0}, {3'd0, 1'b1, 3'd6, 1'b0},
    {3'd1, 1'b0, 3'd0, 1'b1}, {3'd1, 1'b1, 3'd0, 1'b1},
    {3'd2, 1'b0, 3'd4, 1'b0}, {3'd2, 1'b1, 3'd0, 1'b0},
    {3'd3, 1'b0, 3'd0, 1'b1}, {3'd3, 1'b1, 3'd0, 1'b1},
    {3'd4, 1'b0, 3'd6, 1'b0}, {3'd4, 1'b1, 3'd2, 1'b0},
    {3'd5, 1'b0, 3'd0, 1'b1}, {3'd5, 1'b1, 3'd0, 1'b1},
    {3'd6, 1'b0, 3'd0, 1'b0}, {3'd6, 1'b1, 3'd4, 1'b0},
    {3'd7, 1'b0, 3'd0, 1'b1}, {3'd7, 1'b1, 3'd0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic r, input logic ld, input logic [2:0] sc,
                     input logic en, input logic d);
    rst = r; seed_load = ld; seed_code = sc; cnt_en = en; dir_sel = d;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; cnt_en = 1'b0; dir_sel = 1'b0; seed_load = 1'b0; seed_code = 3'd0;
    @(negedge clk);
    cyc(1'b1, 1'b1, 3'd5, 1'b1, 1'b1);
    check("R1 reset state", seq_o, 0);
    check("R1 reset dir", dir_o, 0);
    check("R1 reset flag", recover_o, 0);

    // table walk over all state and direction pairs
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 1'b1, VEC[i][7:5], 1'b1, ~VEC[i][4]);
      check("R8 seed load", seq_o, int'(VEC[i][7:5]));
      check("R8 no flag on load", recover_o, 0);
      cyc(1'b0, 1'b0, 3'd0, 1'b1, VEC[i][4]);
      check("R10 table next-state", seq_o, int'(VEC[i][3:1]));
      check("R4 R7 table flag", recover_o, int'(VEC[i][0]));
      check("R9 table dir", dir_o, int'(VEC[i][4]));
      cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
      check("R7 flag one cycle", recover_o, 0);
    end

    // forward walk from reset
    cyc(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R2 fwd 1", seq_o, 2);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R2 fwd 2", seq_o, 4);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R2 fwd 3", seq_o, 6);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R2 fwd wrap", seq_o, 0);
    check("R7 no flag legal", recover_o, 0);

    // reverse walk
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R3 rev 1", seq_o, 6);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R3 rev 2", seq_o, 4);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R3 rev 3", seq_o, 2);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R3 rev wrap", seq_o, 0);
    check("R9 dir rev", dir_o, 1);

    // direction change applies at once
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R5 fwd step", seq_o, 2);
    check("R9 dir fwd", dir_o, 0);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R5 immediate reverse", seq_o, 0);
    check("R9 dir after change", dir_o, 1);

    // hold with enable low, direction toggling
    cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b0); check("R6 hold code", seq_o, 0);
    check("R6 hold dir", dir_o, 1);
    cyc(1'b0, 1'b1, 3'd4, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b0); check("R6 hold at 4", seq_o, 4);

    // odd code parked with enable low
    cyc(1'b0, 1'b1, 3'd3, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b0); check("R6 hold odd", seq_o, 3);
    check("R7 no flag on hold", recover_o, 0);

    // reset from an odd code
    cyc(1'b1, 1'b0, 3'd0, 1'b1, 1'b0); check("R1 reset from odd", seq_o, 0);
    check("R7 no flag on reset", recover_o, 0);

    // load beats enable
    cyc(1'b0, 1'b1, 3'd5, 1'b1, 1'b1); check("R8 load over enable", seq_o, 5);
    check("R8 dir kept", dir_o, 0);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b1); check("R4 odd to zero rev", seq_o, 0);
    check("R7 flag raised", recover_o, 1);
    cyc(1'b0, 1'b0, 3'd0, 1'b1, 1'b0); check("R7 flag dropped", recover_o, 0);
    check("R2 after recovery", seq_o, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule